// File: doc/BRIEF.md
# Serial Port Register Interface

This block is the register face of a serial port, seen from a simple word-wide bus. It holds a status word, a data slot, a baud divisor, three control words and a guard/prescaler word inside a 1 KB window. Received bytes arrive on a valid/ready byte stream. Transmit bytes leave on a second valid/ready byte stream. A single level interrupt reports that a received byte is waiting. Shifting bits onto a wire, baud timing and parity belong to other blocks. The divisor and guard words are only stored and read back.

The bus side has no wait states. A request is a one-cycle pulse of `bus_sel`, qualified by `bus_wr`. A write takes effect at the clock edge of the request. Read data is registered and appears on `bus_rdata` one cycle after the request, and any side effect of the read takes place at the same edge. Software clears status flags through a two-way write rule. The interrupt follows the receive-full flag through reads, status writes and control writes.

Top module: `serial_csr`

## Requirements
- R1: After reset, status reads 0x000000C0 (bit 7 tx_empty and bit 6 tx_done set). Every other register reads zero, irq and tx_valid are low, and rx_ready is high.
- R2: Word offsets are status 0x00, data 0x04, baud 0x08, ctrl_a 0x0C, ctrl_b 0x10, ctrl_c 0x14 and guard 0x18. The baud, ctrl_a, ctrl_b, ctrl_c and guard words store all 32 written bits and read them back.
- R3: Any other offset in the window, including an unaligned one, reads as zero, and a write to it changes no register.
- R4: rx_ready is high exactly while status bit 5 (rx_full) is clear. No byte is taken and the data slot does not change while rx_full is set.
- R5: A byte taken on the receive stream is stored in the data slot and sets rx_full only when ctrl_a bit 13 (port enable) and ctrl_a bit 2 (receive enable) are both set. Otherwise it is taken and discarded.
- R6: A stored byte raises irq when ctrl_a bit 5 (receive interrupt enable) is set.
- R7: A data read returns the stored byte in bits 7:0 with zeros above, clears rx_full and lowers irq.
- R8: A status write with a value of at most 0x3FF replaces status with that value, with bit 7 forced to 1. A larger value is ANDed into the current status.
- R9: After a status write, irq is low if rx_full is clear. irq is never high while rx_full is clear.
- R10: A data write with a value below 0xF000 queues its low 8 bits for transmit and sets status bit 6. A data write of 0xF000 or more changes nothing.
- R11: A queued byte is held on tx_data with tx_valid high until tx_ready is seen. A later data write replaces a byte that has not yet been taken, and a write in the handshake cycle queues the new byte.
- R12: A ctrl_a write with bit 5 set raises irq at once if rx_full is already set.
- R13: Read data appears on bus_rdata one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | One-cycle bus request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | BYTE_W | Receive byte |
| rx_ready | output | 1 | Receive slot free |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | BYTE_W | Transmit byte |
| tx_ready | input | 1 | Transmit sink takes byte |
| irq | output | 1 | Receive interrupt, level |

## Verification
The main function is tried in two ways. Directed sequences offer bytes with the port disabled, half enabled and fully enabled, to tell a dropped byte from a stored one. They offer bytes while the slot is full, to tell back-pressure from overwrite. They write status on both sides of the 0x3FF split, to tell a replace from an AND-clear, and raise the interrupt enable before and after a byte lands. A long random mix of reads, writes, offered bytes and tx_ready levels then runs against a bench model, which exposes ordering faults between the interrupt, rx_full and the transmit holding slot that directed cases do not line up.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;
  localparam int REG_W = 32;
  localparam int NREG  = 7;

  // register slots; slot index times four is the byte offset
  localparam int IDX_STAT = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_BAUD = 2;
  localparam int IDX_CA   = 3;
  localparam int IDX_CB   = 4;
  localparam int IDX_CC   = 5;
  localparam int IDX_GT   = 6;

  // status bits
  localparam int BIT_RXF = 5;
  localparam int BIT_TXD = 6;
  localparam int BIT_TXE = 7;
  // ctrl_a bits
  localparam int CA_RXE  = 2;
  localparam int CA_RXIE = 5;
  localparam int CA_EN   = 13;

  localparam logic [REG_W-1:0] STAT_RST     = 32'h0000_00C0;
  localparam logic [REG_W-1:0] STAT_OVR_MAX = 32'h0000_03FF;
  localparam logic [REG_W-1:0] TX_WR_LIMIT  = 32'h0000_F000;

  // status write: small values replace (tx_empty forced), large values AND-clear
  function automatic logic [REG_W-1:0] stat_write_merge(
    input logic [REG_W-1:0] cur, input logic [REG_W-1:0] val);
    if (val <= STAT_OVR_MAX) return val | (REG_W'(1) << BIT_TXE);
    return cur & val;
  endfunction

  function automatic logic tx_write_ok(input logic [REG_W-1:0] val);
    return val < TX_WR_LIMIT;
  endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
  parameter int ADDR_W = 10,
  parameter int NSLOT  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSLOT-1:0]  hit
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign hit[g] = (addr == ADDR_W'(g * 4));
  end
endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_full,
  input  logic              rx_on,
  output logic              rx_ready,
  output logic              acc_ev,
  output logic              drop_ev,
  output logic [BYTE_W-1:0] data_q
);
  logic take;
  assign rx_ready = ~rx_full;
  assign take     = rx_valid & rx_ready;
  assign acc_ev   = take & rx_on;
  assign drop_ev  = take & ~rx_on;

  always_ff @(posedge clk) begin
    if (!rst_n)      data_q <= '0;
    else if (acc_ev) data_q <= rx_data;
  end
endmodule

// File: rtl/tx_holding.sv
module tx_holding #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_byte;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_irq_ctl.sv
module stat_irq_ctl
  import serial_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_wr_ev,
  input  logic [REG_W-1:0] wdata,
  input  logic             dr_rd_ev,
  input  logic             tx_load_ev,
  input  logic             ctl_wr_ev,
  input  logic             ctl_new_ie,
  input  logic             acc_ev,
  input  logic             acc_irq_en,
  output logic [REG_W-1:0] stat_q,
  output logic             irq
);
  logic [REG_W-1:0] stat_d;
  logic             irq_d;

  // bus effect first, receive capture last
  always_comb begin
    stat_d = stat_q;
    irq_d  = irq;
    if (stat_wr_ev) begin
      stat_d = stat_write_merge(stat_q, wdata);
      if (!stat_d[BIT_RXF]) irq_d = 1'b0;
    end
    if (dr_rd_ev) begin
      stat_d[BIT_RXF] = 1'b0;
      irq_d = 1'b0;
    end
    if (tx_load_ev) stat_d[BIT_TXD] = 1'b1;
    if (ctl_wr_ev && ctl_new_ie && stat_d[BIT_RXF]) irq_d = 1'b1;
    if (acc_ev) begin
      stat_d[BIT_RXF] = 1'b1;
      if (acc_irq_en) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq    <= irq_d;
    end
  end
endmodule

// File: rtl/serial_csr.sv
module serial_csr
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  // named internal events for the checker
  logic [NREG-1:0]   hit;
  logic              wr_ev, rd_ev;
  logic              stat_wr_ev, dr_rd_ev, tx_load_ev, ctl_wr_ev;
  logic              acc_ev, drop_ev;
  logic              rx_on, rx_irq_en;
  logic [REG_W-1:0]  stat_q;
  logic [BYTE_W-1:0] data_q;
  logic [REG_W-1:0]  store_q [IDX_BAUD:NREG-1];
  logic [REG_W-1:0]  rd_val;

  csr_decode #(.ADDR_W(ADDR_W), .NSLOT(NREG)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  assign wr_ev      = bus_sel & bus_wr;
  assign rd_ev      = bus_sel & ~bus_wr;
  assign stat_wr_ev = wr_ev & hit[IDX_STAT];
  assign dr_rd_ev   = rd_ev & hit[IDX_DATA];
  assign tx_load_ev = wr_ev & hit[IDX_DATA] & tx_write_ok(bus_wdata);
  assign ctl_wr_ev  = wr_ev & hit[IDX_CA];

  assign rx_on     = store_q[IDX_CA][CA_EN] & store_q[IDX_CA][CA_RXE];
  assign rx_irq_en = store_q[IDX_CA][CA_RXIE];

  // plain stored words
  always_ff @(posedge clk) begin
    for (int i = IDX_BAUD; i < NREG; i++) begin
      if (!rst_n)              store_q[i] <= '0;
      else if (wr_ev && hit[i]) store_q[i] <= bus_wdata;
    end
  end

  rx_capture #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_full(stat_q[BIT_RXF]), .rx_on(rx_on), .rx_ready(rx_ready),
    .acc_ev(acc_ev), .drop_ev(drop_ev), .data_q(data_q)
  );

  tx_holding #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load_ev),
    .load_byte(bus_wdata[BYTE_W-1:0]), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  stat_irq_ctl u_stat (
    .clk(clk), .rst_n(rst_n), .stat_wr_ev(stat_wr_ev), .wdata(bus_wdata),
    .dr_rd_ev(dr_rd_ev), .tx_load_ev(tx_load_ev), .ctl_wr_ev(ctl_wr_ev),
    .ctl_new_ie(bus_wdata[CA_RXIE]), .acc_ev(acc_ev),
    .acc_irq_en(rx_irq_en), .stat_q(stat_q), .irq(irq)
  );

  // read mux: unmatched offsets give zero
  always_comb begin
    rd_val = '0;
    if (hit[IDX_STAT]) rd_val = stat_q;
    if (hit[IDX_DATA]) rd_val = REG_W'(data_q);
    for (int i = IDX_BAUD; i < NREG; i++)
      if (hit[i]) rd_val = store_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ev) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/serial_csr_chk.sv
module serial_csr_chk
  import serial_csr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] rx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              irq,
  input logic              acc_ev,
  input logic              drop_ev,
  input logic              dr_rd_ev,
  input logic              stat_wr_ev,
  input logic              ctl_wr_ev,
  input logic              ctl_new_ie,
  input logic              tx_load_ev,
  input logic              rx_irq_en,
  input logic [REG_W-1:0]  stat_q,
  input logic [BYTE_W-1:0] data_q
);
  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(data_q));

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev |=> (stat_q[BIT_RXF] && data_q == $past(rx_data)));

  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> $stable(data_q));

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && rx_irq_en) |=> irq);

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd_ev && !acc_ev) |=> (!irq && !stat_q[BIT_RXF]));

  assert_stat_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_ev && !acc_ev) |=> (stat_q[BIT_RXF] || !irq));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_q[BIT_RXF]);

  assert_tx_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_ev |=> (tx_valid && stat_q[BIT_TXD]));

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_load_ev) |=> (tx_valid && $stable(tx_data)));

  assert_ctl_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_ev && ctl_new_ie && stat_q[BIT_RXF] && !dr_rd_ev) |=> irq);
endmodule

bind serial_csr serial_csr_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .irq(irq), .acc_ev(acc_ev), .drop_ev(drop_ev),
  .dr_rd_ev(dr_rd_ev), .stat_wr_ev(stat_wr_ev), .ctl_wr_ev(ctl_wr_ev),
  .ctl_new_ie(bus_wdata[CA_RXIE]), .tx_load_ev(tx_load_ev),
  .rx_irq_en(rx_irq_en), .stat_q(stat_q), .data_q(data_q)
);

// File: tb/sim_serial_csr.sv
module sim_serial_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic        irq;

  always #5 clk = ~clk;

  serial_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // bench model of the register file
  logic [31:0] m_stat, m_baud, m_ca, m_cb, m_cc, m_gt;
  logic [7:0]  m_data, m_txd;
  logic        m_irq, m_pend;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [9:0] a);
    case (a)
      10'h000: return m_stat;
      10'h004: return {24'h0, m_data};
      10'h008: return m_baud;
      10'h00C: return m_ca;
      10'h010: return m_cb;
      10'h014: return m_cc;
      10'h018: return m_gt;
      default: return 32'h0;
    endcase
  endfunction

  // one clock: drive at negedge, update the model, compare at the next negedge
  task automatic step(bit sel, bit wr, logic [9:0] a, logic [31:0] wd,
                      bit rv, logic [7:0] rb, bit tr, string tag);
    logic [31:0] exp_rd;
    bit          load;
    bit          was_full;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_data = rb; tx_ready = tr;
    chk("R4 rx_ready", {31'h0, rx_ready}, {31'h0, ~m_stat[5]});
    was_full = m_stat[5];
    exp_rd = 32'h0;
    load = 0;
    if (sel && !wr) begin
      exp_rd = model_read(a);
      if (a == 10'h004) begin m_stat[5] = 1'b0; m_irq = 1'b0; end
    end else if (sel && wr) begin
      case (a)
        10'h000: begin
          if (wd <= 32'h3FF) m_stat = wd | 32'h80;
          else m_stat = m_stat & wd;
          if (!m_stat[5]) m_irq = 1'b0;
        end
        10'h004: if (wd < 32'hF000) begin
          load = 1; m_txd = wd[7:0]; m_stat[6] = 1'b1;
        end
        10'h008: m_baud = wd;
        10'h00C: begin m_ca = wd; if (wd[5] && m_stat[5]) m_irq = 1'b1; end
        10'h010: m_cb = wd;
        10'h014: m_cc = wd;
        10'h018: m_gt = wd;
        default: ;
      endcase
    end
    if (rv && !was_full && m_ca[13] && m_ca[2]) begin
      m_data = rb; m_stat[5] = 1'b1;
      if (m_ca[5]) m_irq = 1'b1;
    end
    if (load) m_pend = 1'b1;
    else if (m_pend && tr) m_pend = 1'b0;
    @(negedge clk);
    bus_sel = 0; rx_valid = 0;
    if (sel && !wr) chk({tag, " R13 rdata"}, bus_rdata, exp_rd);
    chk("R6/R9 irq", {31'h0, irq}, {31'h0, m_irq});
    chk("R11 tx_valid", {31'h0, tx_valid}, {31'h0, m_pend});
    if (m_pend) chk("R11 tx_data", {24'h0, tx_data}, {24'h0, m_txd});
  endtask

  task automatic rd(logic [9:0] a, string tag);
    step(1, 0, a, 32'h0, 0, 8'h0, 0, tag);
  endtask
  task automatic wr(logic [9:0] a, logic [31:0] v, string tag);
    step(1, 1, a, v, 0, 8'h0, 0, tag);
  endtask
  task automatic rx(logic [7:0] b, string tag);
    step(0, 0, 10'h0, 32'h0, 1, b, 0, tag);
  endtask

  function automatic logic [9:0] pick_addr();
    case ($urandom % 10)
      0: return 10'h000;
      1: return 10'h004;
      2: return 10'h008;
      3: return 10'h00C;
      4: return 10'h010;
      5: return 10'h014;
      6: return 10'h018;
      7: return 10'h004;
      8: return 10'h00C;
      default: return 10'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 0; rx_data = '0; tx_ready = 0;
    m_stat = 32'hC0; m_baud = 0; m_ca = 0; m_cb = 0; m_cc = 0; m_gt = 0;
    m_data = 0; m_txd = 0; m_irq = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    rd(10'h000, "R1");
    chk("R1 status literal", bus_rdata, 32'h0000_00C0);
    for (int k = 1; k < 7; k++) rd(10'(k * 4), "R1");

    // R2 storage and readback
    wr(10'h008, 32'h1234_5678, "R2"); rd(10'h008, "R2");
    chk("R2 baud literal", bus_rdata, 32'h1234_5678);
    wr(10'h010, 32'hDEAD_BEEF, "R2"); rd(10'h010, "R2");
    wr(10'h014, 32'hA5A5_0F0F, "R2"); rd(10'h014, "R2");
    wr(10'h018, 32'h0000_FFFF, "R2"); rd(10'h018, "R2");

    // R3 undefined offsets
    wr(10'h01C, 32'hFFFF_FFFF, "R3"); wr(10'h3FC, 32'hFFFF_FFFF, "R3");
    wr(10'h00A, 32'hFFFF_FFFF, "R3"); wr(10'h002, 32'h0000_0000, "R3");
    rd(10'h01C, "R3"); rd(10'h3FC, "R3"); rd(10'h009, "R3");
    rd(10'h008, "R3"); rd(10'h000, "R3");

    // R5 gating: disabled, half enabled, enabled
    rx(8'h11, "R5"); rd(10'h004, "R5");
    wr(10'h00C, 32'h0000_2000, "R5"); rx(8'h22, "R5"); rd(10'h004, "R5");
    wr(10'h00C, 32'h0000_2004, "R5"); rx(8'h5A, "R5");
    // R4 back-pressure while full
    rx(8'h77, "R4"); rx(8'h78, "R4");
    rd(10'h004, "R7");
    chk("R7 data literal", bus_rdata, 32'h0000_005A);

    // R6 / R7 interrupt path
    wr(10'h00C, 32'h0000_2024, "R6"); rx(8'hC3, "R6");
    chk("R6 irq literal", {31'h0, irq}, 32'h1);
    rd(10'h004, "R7");
    chk("R7 irq cleared", {31'h0, irq}, 32'h0);

    // R12 late enable
    wr(10'h00C, 32'h0000_2004, "R12"); rx(8'h3C, "R12");
    wr(10'h00C, 32'h0000_2024, "R12");
    chk("R12 irq literal", {31'h0, irq}, 32'h1);

    // R8 / R9 status writes
    wr(10'h000, 32'hFFFF_FFFF, "R8"); rd(10'h000, "R8");
    wr(10'h000, 32'h0000_0000, "R9");
    chk("R9 irq literal", {31'h0, irq}, 32'h0);
    rd(10'h000, "R8");
    chk("R8 status literal", bus_rdata, 32'h0000_0080);
    wr(10'h000, 32'h0000_03FF, "R8"); rd(10'h000, "R8");
    wr(10'h000, 32'hFFFF_FF3F, "R8"); rd(10'h000, "R8");
    chk("R8 and literal", bus_rdata, 32'h0000_033F);
    wr(10'h000, 32'h0000_0000, "R8");

    // R10 / R11 transmit path
    wr(10'h004, 32'h0000_01A5, "R10"); rd(10'h000, "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R11"); step(0, 0, 0, 0, 0, 0, 0, "R11");
    wr(10'h004, 32'h0000_0042, "R11");
    step(0, 0, 0, 0, 0, 0, 1, "R11");
    wr(10'h000, 32'h0000_0000, "R10");
    wr(10'h004, 32'h0000_F000, "R10"); rd(10'h000, "R10");
    wr(10'h004, 32'h0000_EFFF, "R10");
    step(1, 1, 10'h004, 32'h0000_0099, 0, 0, 1, "R11");
    step(0, 0, 0, 0, 0, 0, 1, "R11");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned kind;
      logic [9:0]  a;
      logic [31:0] v;
      bit          tr;
      kind = $urandom % 4;
      a    = pick_addr();
      tr   = 1'($urandom);
      v    = $urandom;
      if (a == 10'h000 && ($urandom % 2)) v = v % 32'h400;
      if (a == 10'h004 && ($urandom % 2)) v = v & 32'hFFFF;
      if (a == 10'h00C && ($urandom % 2)) v = v | 32'h2024;
      case (kind)
        0: step(1, 0, a, 0, 0, 0, tr, "R2/R3 rand");
        1: step(1, 1, a, v, 0, 0, tr, "R8/R10 rand");
        2: step(0, 0, 0, 0, 1, 8'($urandom), tr, "R5 rand");
        default: step(0, 0, 0, 0, 0, 0, tr, "R11 rand");
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule